// File: doc/BRIEF.md
# DMA Burst Command Fragmenter

This block turns one transfer request into the stream of bus commands for one side of a DMA transfer, either the read side or the write side. A request describes a two-dimensional layout: a row length in bytes, a number of rows, a row pitch in bytes and a start address. The block emits commands that each carry a byte address and a byte length. No command is longer than the burst size, and no command crosses a burst-aligned boundary.

When the pitch equals the row length, the rows are adjacent in memory. The block then merges them into a single contiguous run, so that full-size bursts can be used. Otherwise each row is cut into commands on its own. An unaligned start is trimmed so that later commands fall on burst boundaries. On the read side, a gap value captured with the request inserts idle cycles between successive commands. This keeps the block from flooding a slave's command queue. The write side ignores the gap.

A request is accepted through a valid/ready handshake. Commands leave through a second valid/ready handshake. A one-cycle completion pulse follows the final command, and the block takes a new request only when it is idle.

Top module: `dma_cmd_slicer`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `req_ready` is 1, `cmd_valid` is 0 and `done` is 0. A reset in the middle of a request abandons that request.
- R2: Every command has a length from 1 to BURST_BYTES (default 64). Its address offset within a burst plus its length never exceeds BURST_BYTES, so no command crosses a 64-byte aligned boundary.
- R3: Within a run, the first command ends at the next burst boundary. The following commands are full bursts, and the last command carries the remainder. For example, 128 bytes from address 63 give lengths 1, 64 and 63, and 128 bytes from address 513 give lengths 63, 64 and 1.
- R4: When the pitch equals the row length, the request is handled as one run of row length × row count bytes starting at the request address. For example, 8 rows of 8 bytes at address 64 give one 64-byte command.
- R5: When the pitch differs from the row length, each row is fragmented separately. Row k starts at the start address plus k × pitch, taken modulo 2^32, with the pitch treated as unsigned. For example, 8 rows of 8 bytes with pitch 10 give eight separate row runs.
- R6: For a read request (`req_is_read` = 1) with the output always ready, successive command handshakes of one request are exactly gap+1 cycles apart, where gap is `req_gap` sampled at acceptance.
- R7: For a write request (`req_is_read` = 0), the gap value has no effect. With the output always ready, successive handshakes fall on consecutive cycles.
- R8: The first command of a request is presented in the cycle after the request is accepted, whatever the gap value.
- R9: A request whose row length or row count is zero produces no command. `done` is raised in the cycle after acceptance.
- R10: `done` is high for exactly one cycle, in the cycle after the final command handshake. `req_ready` is 0 from acceptance until `done` has been seen and returns to 1 in the following cycle.
- R11: While `cmd_valid` is 1 and `cmd_ready` is 0, the command stays valid and its address and length stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle and able to take a request |
| req_row_bytes | input | 16 | Bytes per row |
| req_rows | input | 16 | Number of rows |
| req_pitch | input | 16 | Byte distance between row starts (unsigned) |
| req_addr | input | 32 | Start byte address |
| req_is_read | input | 1 | 1: read side, paced; 0: write side |
| req_gap | input | 8 | Idle cycles between read commands |
| cmd_valid | output | 1 | Command offered |
| cmd_ready | input | 1 | Command taken |
| cmd_addr | output | 32 | Command byte address |
| cmd_len | output | 7 | Command byte length, 1 to 64 |
| done | output | 1 | One-cycle pulse after the last command of a request |

## Verification
A wrong row base, remaining count or current address appears directly on `cmd_addr` or `cmd_len` at the next command handshake. A wrong row countdown shows up as missing or extra commands, and `done` then arrives too early or too late, by at least one full row. A pacing counter that loads or clears badly breaks the spacing between handshakes on the first paced command after the fault. A state machine stuck outside idle is visible as `req_ready` staying low after the completion pulse.

// File: rtl/dmaf_pkg.sv
// Shared types for the DMA burst command fragmenter.
// Assumes nothing beyond a two-bit state encoding.
package dmaf_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } dmaf_state_e;

endpackage

// File: rtl/dmaf_chunk.sv
// Chunk sizer: picks the length of the next command as the smaller of the
// bytes left in the current run and the room up to the next burst boundary.
// Assumes BURST_BYTES is a power of two.
module dmaf_chunk #(
    parameter int BURST_BYTES = 64,
    parameter int REM_W       = 32,
    localparam int OFF_W      = $clog2(BURST_BYTES),
    localparam int LEN_W      = OFF_W + 1
) (
    input  logic [OFF_W-1:0] addr_off,
    input  logic [REM_W-1:0] remaining,
    output logic [LEN_W-1:0] len
);

    logic [LEN_W-1:0] room;

    // Room left before the next burst boundary.
    assign room = LEN_W'(BURST_BYTES) - LEN_W'(addr_off);

    // Clip the run remainder to the room.
    always_comb begin
        if (remaining < REM_W'(room)) begin
            len = LEN_W'(remaining);
        end else begin
            len = room;
        end
    end

endmodule

// File: rtl/dmaf_row_walker.sv
// Row walker: holds the current address, the bytes left in the current row
// run and the rows still to go. Advances by one chunk per command handshake
// and steps the row base by the pitch at the end of each row.
// Assumes load and fire are never high together.
module dmaf_row_walker #(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16,
    parameter int LEN_W  = 7,
    localparam int REM_W = 2 * CNT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic [REM_W-1:0]  ld_row_len,
    input  logic [CNT_W-1:0]  ld_rows,
    input  logic [CNT_W-1:0]  ld_pitch,
    input  logic              fire,
    input  logic [LEN_W-1:0]  len,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [REM_W-1:0]  remaining,
    output logic              last_cmd
);

    logic [ADDR_W-1:0] row_base;
    logic [REM_W-1:0]  row_len_q;
    logic [CNT_W-1:0]  rows_left;
    logic [CNT_W-1:0]  pitch_q;
    logic [ADDR_W-1:0] next_base;
    logic              row_end;

    // Start address of the following row.
    assign next_base = row_base + ADDR_W'(pitch_q);
    // This chunk closes the current row.
    assign row_end   = (remaining == REM_W'(len));
    // This chunk closes the whole request.
    assign last_cmd  = row_end && (rows_left == CNT_W'(1));

    // Load a new request, or advance by one chunk on each handshake.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_base  <= '0;
            cur_addr  <= '0;
            remaining <= '0;
            row_len_q <= '0;
            rows_left <= '0;
            pitch_q   <= '0;
        end else if (load) begin
            row_base  <= ld_addr;
            cur_addr  <= ld_addr;
            remaining <= ld_row_len;
            row_len_q <= ld_row_len;
            rows_left <= ld_rows;
            pitch_q   <= ld_pitch;
        end else if (fire) begin
            if (row_end) begin
                rows_left <= rows_left - CNT_W'(1);
                if (!last_cmd) begin
                    row_base  <= next_base;
                    cur_addr  <= next_base;
                    remaining <= row_len_q;
                end else begin
                    remaining <= '0;
                end
            end else begin
                cur_addr  <= cur_addr + ADDR_W'(len);
                remaining <= remaining - REM_W'(len);
            end
        end
    end

    // R5: a handshake that does not close the request leaves bytes to send.
    p_more_after_mid_r5: assert property (@(posedge clk) disable iff (!rst_n)
        fire && !last_cmd |=> remaining != '0);

    // R5: a new row starts exactly one pitch after the previous row start.
    p_row_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        fire && row_end && !last_cmd |=> cur_addr == $past(row_base) + ADDR_W'(pitch_q));

endmodule

// File: rtl/dmaf_pacer.sv
// Read pacer: after each handshake on the read side, holds off the next
// command for a programmed number of idle cycles. Cleared at each new
// request so that the first command is never delayed.
module dmaf_pacer #(
    parameter int RATE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              fire,
    input  logic              enable,
    input  logic [RATE_W-1:0] gap,
    output logic              ok
);

    logic [RATE_W-1:0] wait_cnt;

    // The pacer permits a command only once the wait has run out.
    assign ok = (wait_cnt == '0);

    // Load the gap after a paced handshake, then count it down.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wait_cnt <= '0;
        end else if (clear) begin
            wait_cnt <= '0;
        end else if (fire && enable) begin
            wait_cnt <= gap;
        end else if (wait_cnt != '0) begin
            wait_cnt <= wait_cnt - RATE_W'(1);
        end
    end

    // R6: a paced handshake with a non-zero gap blocks the next cycle.
    p_hold_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
        fire && enable && !clear && gap != '0 |=> !ok);

endmodule

// File: rtl/dma_cmd_slicer.sv
// DMA burst command fragmenter top level. Accepts one request at a time,
// merges adjacent rows into a single run when the pitch equals the row
// length, and issues burst-bounded commands with optional read pacing.
// Assumes BURST_BYTES is a power of two and fits in LEN_W bits.
module dma_cmd_slicer #(
    parameter int ADDR_W      = 32,
    parameter int CNT_W       = 16,
    parameter int BURST_BYTES = 64,
    parameter int RATE_W      = 8,
    localparam int OFF_W      = $clog2(BURST_BYTES),
    localparam int LEN_W      = OFF_W + 1,
    localparam int REM_W      = 2 * CNT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [CNT_W-1:0]  req_row_bytes,
    input  logic [CNT_W-1:0]  req_rows,
    input  logic [CNT_W-1:0]  req_pitch,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_is_read,
    input  logic [RATE_W-1:0] req_gap,
    output logic              cmd_valid,
    input  logic              cmd_ready,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic [LEN_W-1:0]  cmd_len,
    output logic              done
);

    import dmaf_pkg::*;

    dmaf_state_e       state;
    logic              rd_q;
    logic [RATE_W-1:0] gap_q;
    logic              start;
    logic              empty_req;
    logic              contig;
    logic              load;
    logic              cmd_fire;
    logic              pace_ok;
    logic              last_cmd;
    logic [REM_W-1:0]  ld_row_len;
    logic [CNT_W-1:0]  ld_rows;
    logic [REM_W-1:0]  remaining;

    // Handshake and request classification.
    assign req_ready = (state == ST_IDLE);
    assign start     = req_valid && req_ready;
    assign empty_req = (req_row_bytes == '0) || (req_rows == '0);
    assign contig    = (req_pitch == req_row_bytes);
    assign load      = start && !empty_req;
    assign cmd_valid = (state == ST_RUN) && pace_ok;
    assign cmd_fire  = cmd_valid && cmd_ready;
    assign done      = (state == ST_DONE);

    // Shape of the run: one merged row, or one run per row.
    assign ld_row_len = contig ? REM_W'(req_row_bytes) * REM_W'(req_rows)
                               : REM_W'(req_row_bytes);
    assign ld_rows    = contig ? CNT_W'(1) : req_rows;

    // Request sequencing: idle, issuing, completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            case (state)
                ST_IDLE: if (start) state <= empty_req ? ST_DONE : ST_RUN;
                ST_RUN:  if (cmd_fire && last_cmd) state <= ST_DONE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Capture the side and the gap with the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q  <= 1'b0;
            gap_q <= '0;
        end else if (start) begin
            rd_q  <= req_is_read;
            gap_q <= req_gap;
        end
    end

    dmaf_row_walker #(
        .ADDR_W (ADDR_W),
        .CNT_W  (CNT_W),
        .LEN_W  (LEN_W)
    ) u_walk (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (load),
        .ld_addr    (req_addr),
        .ld_row_len (ld_row_len),
        .ld_rows    (ld_rows),
        .ld_pitch   (req_pitch),
        .fire       (cmd_fire),
        .len        (cmd_len),
        .cur_addr   (cmd_addr),
        .remaining  (remaining),
        .last_cmd   (last_cmd)
    );

    dmaf_chunk #(
        .BURST_BYTES (BURST_BYTES),
        .REM_W       (REM_W)
    ) u_chunk (
        .addr_off  (cmd_addr[OFF_W-1:0]),
        .remaining (remaining),
        .len       (cmd_len)
    );

    dmaf_pacer #(
        .RATE_W (RATE_W)
    ) u_pace (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (start),
        .fire   (cmd_fire),
        .enable (rd_q),
        .gap    (gap_q),
        .ok     (pace_ok)
    );

    // R2: command length stays within one burst and is never empty.
    p_len_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> cmd_len != '0 && cmd_len <= LEN_W'(BURST_BYTES));

    // R2: no command crosses a burst-aligned boundary.
    p_no_cross_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> ((LEN_W+1)'(cmd_addr[OFF_W-1:0]) + (LEN_W+1)'(cmd_len))
                      <= (LEN_W+1)'(BURST_BYTES));

    // R7: write commands follow each other without idle cycles.
    p_write_b2b_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_fire && !rd_q && !last_cmd |=> cmd_valid);

    // R8: a non-empty request presents its first command next cycle.
    p_first_next_r8: assert property (@(posedge clk) disable iff (!rst_n)
        start && !empty_req |=> cmd_valid);

    // R9: an empty request completes next cycle with no command.
    p_empty_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        start && empty_req |=> done && !cmd_valid);

    // R10: completion is a single-cycle pulse followed by idle.
    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done && req_ready);

    // R10: nothing is issued while the block is idle.
    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !cmd_valid && !done);

    // R11: a stalled command holds its address and length.
    p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_addr) && $stable(cmd_len));

endmodule

// File: tb/sim_dma_cmd_slicer.sv
// Self-checking bench for dma_cmd_slicer: table-driven requests compared
// against a reference built from the requirements, then directed cases.
module sim_dma_cmd_slicer;

    localparam int CLK_PERIOD = 10;
    localparam int NV = 9;

    // Vector table: row bytes, rows, pitch, address, read, gap, backpressure.
    localparam int unsigned V_EB [NV] = '{8,   8,  128, 128, 20, 0, 16, 300,  64};
    localparam int unsigned V_CN [NV] = '{8,   8,  1,   1,   5,  4, 0,  3,    2};
    localparam int unsigned V_PI [NV] = '{10,  8,  0,   128, 100,4, 16, 300,  0};
    localparam int unsigned V_AD [NV] = '{191, 64, 63,  513, 30, 0, 0,  1000, 0};
    localparam int unsigned V_RD [NV] = '{0,   1,  1,   0,   1,  1, 0,  1,    0};
    localparam int unsigned V_GP [NV] = '{5,   2,  3,   0,   0,  1, 0,  1,    0};
    localparam int unsigned V_BP [NV] = '{0,   0,  0,   0,   1,  0, 0,  0,    0};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [15:0] req_row_bytes = '0;
    logic [15:0] req_rows = '0;
    logic [15:0] req_pitch = '0;
    logic [31:0] req_addr = '0;
    logic        req_is_read = 1'b0;
    logic [7:0]  req_gap = '0;
    logic        cmd_valid;
    logic        cmd_ready = 1'b1;
    logic [31:0] cmd_addr;
    logic [6:0]  cmd_len;
    logic        done;

    int n_tests = 0;
    int n_fail  = 0;

    bit [31:0] exp_a[$];
    bit [31:0] exp_l[$];
    bit [31:0] got_a[$];
    bit [31:0] got_l[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    dma_cmd_slicer u0 (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .req_ready     (req_ready),
        .req_row_bytes (req_row_bytes),
        .req_rows      (req_rows),
        .req_pitch     (req_pitch),
        .req_addr      (req_addr),
        .req_is_read   (req_is_read),
        .req_gap       (req_gap),
        .cmd_valid     (cmd_valid),
        .cmd_ready     (cmd_ready),
        .cmd_addr      (cmd_addr),
        .cmd_len       (cmd_len),
        .done          (done)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Reference fragmentation built from R2 to R5.
    task automatic build_model(input int unsigned eb, input int unsigned cn,
                               input int unsigned pi, input int unsigned ad);
        bit [31:0] base;
        bit [31:0] a;
        longint    rem;
        longint    rlen;
        int        nrows;
        longint    room;
        exp_a.delete();
        exp_l.delete();
        if (eb == 0 || cn == 0) return;
        rlen  = (pi == eb) ? longint'(eb) * longint'(cn) : longint'(eb);
        nrows = (pi == eb) ? 1 : int'(cn);
        base  = ad;
        for (int r = 0; r < nrows; r++) begin
            a   = base;
            rem = rlen;
            while (rem > 0) begin
                room = 64 - longint'(a % 64);
                if (room > rem) room = rem;
                exp_a.push_back(a);
                exp_l.push_back(32'(room));
                a   = a + 32'(room);
                rem = rem - room;
            end
            base = base + pi;
        end
    endtask

    task automatic run_vec(input int unsigned eb, input int unsigned cn,
                           input int unsigned pi, input int unsigned ad,
                           input bit rd, input int unsigned gp, input bit bp,
                           input string tag);
        int acc_cyc  = -1;
        int first_c  = -1;
        int done_cyc = -1;
        int last_hs  = -1;
        int prev_hs  = -1;
        int gap_bad  = 0;
        int hold_bad = 0;
        int busy_bad = 0;
        bit pend     = 1'b0;
        bit [31:0] pa = '0;
        bit [6:0]  pl = '0;
        bit ready_after = 1'b0;
        int n;
        build_model(eb, cn, pi, ad);
        got_a.delete();
        got_l.delete();
        @(negedge clk);
        req_row_bytes = 16'(eb);
        req_rows      = 16'(cn);
        req_pitch     = 16'(pi);
        req_addr      = ad;
        req_is_read   = rd;
        req_gap       = 8'(gp);
        req_valid     = 1'b1;
        for (int t = 0; t < 3000; t++) begin
            cmd_ready = bp ? (t % 3 != 1) : 1'b1;
            #1;
            if (done_cyc >= 0 && t == done_cyc + 1) begin
                ready_after = req_ready;
                break;
            end
            if (req_valid && req_ready) acc_cyc = t;
            if (acc_cyc >= 0 && t > acc_cyc && done_cyc < 0 && req_ready) busy_bad++;
            if (pend && (!cmd_valid || cmd_addr != pa || cmd_len != pl)) hold_bad++;
            if (cmd_valid && first_c < 0) first_c = t;
            pend = cmd_valid && !cmd_ready;
            pa   = cmd_addr;
            pl   = cmd_len;
            if (cmd_valid && cmd_ready) begin
                got_a.push_back(cmd_addr);
                got_l.push_back(32'(cmd_len));
                if (prev_hs >= 0 && !bp && (t - prev_hs) != (rd ? int'(gp) + 1 : 1)) gap_bad++;
                prev_hs = t;
                last_hs = t;
            end
            if (done) done_cyc = t;
            @(negedge clk);
            if (acc_cyc == t) req_valid = 1'b0;
        end
        req_valid = 1'b0;
        cmd_ready = 1'b1;
        chk(done_cyc >= 0, "R10", {tag, " completion seen"}, done_cyc >= 0, 1);
        chk(got_a.size() == exp_a.size(), "R2/R5", {tag, " command count"},
            got_a.size(), exp_a.size());
        n = (got_a.size() < exp_a.size()) ? got_a.size() : exp_a.size();
        for (int i = 0; i < n; i++) begin
            chk(got_a[i] == exp_a[i], "R3/R4", {tag, " cmd address"}, got_a[i], exp_a[i]);
            chk(got_l[i] == exp_l[i], "R2/R3", {tag, " cmd length"}, got_l[i], exp_l[i]);
        end
        if (exp_a.size() > 0) begin
            chk(first_c == acc_cyc + 1, "R8", {tag, " first cmd latency"}, first_c - acc_cyc, 1);
            chk(done_cyc == last_hs + 1, "R10", {tag, " done after last"}, done_cyc - last_hs, 1);
        end else begin
            chk(done_cyc == acc_cyc + 1, "R9", {tag, " empty done latency"}, done_cyc - acc_cyc, 1);
        end
        if (!bp && exp_a.size() > 1) begin
            if (rd) chk(gap_bad == 0, "R6", {tag, " read spacing"}, gap_bad, 0);
            else    chk(gap_bad == 0, "R7", {tag, " write spacing"}, gap_bad, 0);
        end
        if (bp) chk(hold_bad == 0, "R11", {tag, " stall hold"}, hold_bad, 0);
        chk(busy_bad == 0, "R10", {tag, " ready low while busy"}, busy_bad, 0);
        chk(ready_after == 1'b1, "R10", {tag, " ready after done"}, ready_after, 1);
    endtask

    function automatic string vec_tag(input int i);
        case (i)
            0: return "pitched write, gap ignored R5 R7";
            1: return "merged rows R4";
            2: return "unaligned 63 R3 R6";
            3: return "unaligned 513 R3";
            4: return "backpressure R11";
            5: return "zero row bytes R9";
            6: return "zero rows R9";
            7: return "long merged read R6";
            default: return "zero pitch rows R5";
        endcase
    endfunction

    // Watchdog: a hung run counts as one failure and still prints the summary.
    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL R10 watchdog expired: got 0 expected 1");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(req_ready == 1'b1, "R1", "reset req_ready", req_ready, 1);
        chk(cmd_valid == 1'b0, "R1", "reset cmd_valid", cmd_valid, 0);
        chk(done == 1'b0, "R1", "reset done", done, 0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            run_vec(V_EB[i], V_CN[i], V_PI[i], V_AD[i], V_RD[i][0], V_GP[i], V_BP[i][0],
                    vec_tag(i));
            if (i == 1) begin
                chk(got_l.size() == 1 && got_l[0] == 64 && got_a[0] == 64, "R4",
                    "8x8 pitch 8 one 64-byte cmd", got_l.size(), 1);
            end
            if (i == 2 && got_l.size() == 3) begin
                chk(got_l[0] == 1 && got_l[1] == 64 && got_l[2] == 63, "R3",
                    "lengths 1,64,63 from 63", got_l[0], 1);
            end
            if (i == 3 && got_l.size() == 3) begin
                chk(got_l[0] == 63 && got_l[1] == 64 && got_l[2] == 1, "R3",
                    "lengths 63,64,1 from 513", got_l[0], 63);
            end
            if (i == 8 && got_a.size() == 2) begin
                chk(got_a[1] == 0, "R5", "zero pitch repeats row start", got_a[1], 0);
            end
        end

        // R1: reset in the middle of a request abandons it.
        @(negedge clk);
        req_row_bytes = 16'd512;
        req_rows      = 16'd1;
        req_pitch     = 16'd512;
        req_addr      = 32'd0;
        req_is_read   = 1'b1;
        req_gap       = 8'd0;
        req_valid     = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk(cmd_valid == 1'b0, "R1", "mid-request reset cmd_valid", cmd_valid, 0);
        chk(req_ready == 1'b1, "R1", "mid-request reset req_ready", req_ready, 1);
        rst_n = 1'b1;
        @(negedge clk);
        chk(cmd_valid == 1'b0 && done == 1'b0, "R1", "quiet after reset release",
            cmd_valid, 0);

        run_vec(V_EB[3], V_CN[3], V_PI[3], V_AD[3], V_RD[3][0], V_GP[3], V_BP[3][0],
                "recovery after reset R1");

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule